// File: doc/BRIEF.md
# Low-Power Wake-Up Source Controller

This block decides when and how the device leaves its two low-power modes, Stop and Sleep. The host requests a low-power entry with a one-cycle pulse and chooses the mode. From then on the controller watches a set of wake sources: switch inputs that change level, a cyclic-sense result, a forced-timer expiry, a LIN wake indication, a rising edge on chip-select and an external reset pin that it deglitches itself. Each source has an enable. The controller acts only on the first qualifying event after entry.

The action depends on the mode. In Stop, a reportable source raises a one-cycle interrupt and returns the device to Normal. In Sleep, the supply regulator is switched back on and a host reset is held for a fixed number of cycles. Chip-select and the external reset leave no trace in the sticky wake-status register. The host reads that register through a small read port, and the read clears it. A second address of the port returns the live switch levels.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, mode is Normal (code 0), reg_en is 1, host_rst and wake_irq are 0, and the status register reads 0.
- R2: In Stop (mode code 1), an enabled reportable event moves mode to Normal on the next clock edge and raises wake_irq for exactly one cycle.
- R3: In Sleep (mode code 2), reg_en is 0. An enabled reportable event sets reg_en to 1 and holds host_rst for RST_CYC cycles, during which mode reads Normal. Mode then stays Normal with host_rst low.
- R4: A rising edge on cs wakes from Stop to Normal with no interrupt and no status bit. In Sleep it has no effect.
- R5: When ext_rst_n has been sampled low on DGL_CYC consecutive edges, host_rst rises. In Stop this wakes the device without an interrupt or status bit, to mode 3 (normal request) if nreq_cfg is 1 and to mode 0 if it is 0. host_rst falls on the first edge that samples the pin high.
- R6: A switch input wakes the device when its level differs from the level captured at entry and its enable bit is set. The input selected by mux_on/mux_idx never wakes the device.
- R7: A forced-timer event counts only when cyc_en is 0. When both cyclic and forced enables are set, only the cyclic event wakes the device.
- R8: Status layout: bits [NSW-1:0] are the switch inputs, bit NSW is cyclic, NSW+1 is forced, NSW+2 is LIN (0x10, 0x20, 0x40 for NSW=4). Bits are sticky across wakes and are cleared by a read of address 0.
- R9: A read of address 1 returns the current switch input levels in the low NSW bits.
- R10: Wake events in Normal mode are ignored. Events that arrive after the first wake of an entry set no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_enter | input | 1 | One-cycle request to enter low power |
| lp_sel | input | 1 | Low-power kind: 0 Stop, 1 Sleep |
| nreq_cfg | input | 1 | Static: external-reset wake goes to normal request |
| sw_in | input | NSW | Switch input levels |
| sw_en | input | NSW | Per-switch wake enables |
| mux_on | input | 1 | A switch is routed to the analog multiplexer |
| mux_idx | input | $clog2(NSW) | Index of the routed switch |
| cyc_evt | input | 1 | Cyclic-sense change pulse |
| cyc_en | input | 1 | Cyclic-sense wake enable |
| frc_evt | input | 1 | Forced-timer expiry pulse |
| frc_en | input | 1 | Forced wake enable |
| lin_evt | input | 1 | LIN wake pulse |
| lin_en | input | 1 | LIN wake enable |
| cs | input | 1 | Chip-select level |
| ext_rst_n | input | 1 | Raw external reset pin, active low |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 status (clear on read), 1 switch levels |
| rd_data | output | NSW+3 | Read data |
| wake_irq | output | 1 | One-cycle wake interrupt |
| reg_en | output | 1 | Supply regulator enable |
| host_rst | output | 1 | Reset to the host |
| mode | output | 2 | 0 Normal, 1 Stop, 2 Sleep, 3 Normal request |

## Verification
The assertions assume that every input is synchronous to clk, that the event inputs are single-cycle pulses, that mux_idx is below NSW, and that lp_enter is pulsed only while the device runs. The bench drives all inputs on the falling edge and holds each event high for one cycle. It picks switch indices and enables within range and requests an entry only from Normal, so each property sees only inputs it is allowed to see.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_STOP   = 2'd1,
    MD_SLEEP  = 2'd2,
    MD_NREQ   = 2'd3
  } md_e;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_STOP   = 2'd1,
    PH_SLEEP  = 2'd2,
    PH_RSTOUT = 2'd3
  } ph_e;

  // forced wake only qualifies when cyclic sense is off
  function automatic logic frc_qual(input logic cyc_on, input logic frc_on);
    return frc_on & ~cyc_on;
  endfunction

  function automatic md_e xrst_target(input logic nreq);
    return nreq ? MD_NREQ : MD_NORMAL;
  endfunction
endpackage

// File: rtl/lpw_deglitch.sv
module lpw_deglitch #(
  parameter int DGL_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic held
);
  localparam int CW = (DGL_CYC < 2) ? 1 : $clog2(DGL_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 1'b0;
    end else if (pin_n) begin
      cnt  <= '0;
      held <= 1'b0;
    end else if (cnt == CW'(DGL_CYC - 1)) begin
      held <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_n |=> !held);
endmodule

// File: rtl/lpw_src.sv
module lpw_src #(
  parameter int NSW = 4,
  localparam int MXW = (NSW < 2) ? 1 : $clog2(NSW),
  localparam int STW = NSW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [NSW-1:0] sw_in,
  input  logic [NSW-1:0] sw_en,
  input  logic           mux_on,
  input  logic [MXW-1:0] mux_idx,
  input  logic           cyc_evt,
  input  logic           cyc_en,
  input  logic           frc_evt,
  input  logic           frc_en,
  input  logic           lin_evt,
  input  logic           lin_en,
  input  logic           cs,
  output logic [STW-1:0] rep_hit,
  output logic           cs_rise
);
  import lpw_pkg::*;

  function automatic logic [NSW-1:0] route_mask(input logic on, input logic [MXW-1:0] idx);
    logic [NSW-1:0] m;
    m = '0;
    for (int i = 0; i < NSW; i++) m[i] = on && (idx == MXW'(i));
    return m;
  endfunction

  function automatic logic [NSW-1:0] sw_change(input logic [NSW-1:0] now,
                                               input logic [NSW-1:0] base,
                                               input logic [NSW-1:0] en,
                                               input logic [NSW-1:0] blk);
    return (now ^ base) & en & ~blk;
  endfunction

  logic [NSW-1:0] sw_ref;
  logic           cs_q;
  logic [NSW-1:0] sw_hit;
  logic [NSW-1:0] mux_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_ref <= '0;
      cs_q   <= 1'b0;
    end else begin
      cs_q <= cs;
      if (capture) sw_ref <= sw_in;
    end
  end

  assign mux_blk = route_mask(mux_on, mux_idx);
  assign sw_hit  = sw_change(sw_in, sw_ref, sw_en, mux_blk);
  assign cs_rise = cs & ~cs_q;

  assign rep_hit = {lin_evt & lin_en,
                    frc_evt & frc_qual(cyc_en, frc_en),
                    cyc_evt & cyc_en,
                    sw_hit};

  // R4
  cs_edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !cs_rise);
endmodule

// File: rtl/lpw_stat.sv
module lpw_stat #(
  parameter int NSW = 4,
  localparam int STW = NSW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] set,
  input  logic           rd_en,
  input  logic           rd_addr,
  input  logic [NSW-1:0] sw_in,
  output logic [STW-1:0] rd_data
);
  logic [STW-1:0] stat;
  logic           clr;

  assign clr = rd_en && !rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (clr ? '0 : stat) | set;
  end

  always_comb begin
    if (rd_addr) rd_data = STW'(sw_in);
    else         rd_data = stat;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && !clr) |=> $stable(stat));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> stat == '0);
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl #(
  parameter int NSW     = 4,
  parameter int DGL_CYC = 75,
  parameter int RST_CYC = 16,
  localparam int MXW = (NSW < 2) ? 1 : $clog2(NSW),
  localparam int STW = NSW + 3,
  localparam int RCW = (RST_CYC < 2) ? 1 : $clog2(RST_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lp_enter,
  input  logic           lp_sel,
  input  logic           nreq_cfg,
  input  logic [NSW-1:0] sw_in,
  input  logic [NSW-1:0] sw_en,
  input  logic           mux_on,
  input  logic [MXW-1:0] mux_idx,
  input  logic           cyc_evt,
  input  logic           cyc_en,
  input  logic           frc_evt,
  input  logic           frc_en,
  input  logic           lin_evt,
  input  logic           lin_en,
  input  logic           cs,
  input  logic           ext_rst_n,
  input  logic           rd_en,
  input  logic           rd_addr,
  output logic [STW-1:0] rd_data,
  output logic           wake_irq,
  output logic           reg_en,
  output logic           host_rst,
  output logic [1:0]     mode
);
  import lpw_pkg::*;

  ph_e            ph;
  md_e            run_md;
  logic [RCW-1:0] rcnt;

  // named internal events
  logic           xheld;
  logic           cs_rise;
  logic [STW-1:0] rep_hit;
  logic           rep_any;
  logic           capture;
  logic           stop_wake;
  logic           sleep_wake;
  logic [STW-1:0] stat_set;

  lpw_deglitch #(.DGL_CYC(DGL_CYC)) u_dgl (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_rst_n), .held(xheld)
  );

  lpw_src #(.NSW(NSW)) u_src (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .sw_in(sw_in), .sw_en(sw_en), .mux_on(mux_on), .mux_idx(mux_idx),
    .cyc_evt(cyc_evt), .cyc_en(cyc_en), .frc_evt(frc_evt), .frc_en(frc_en),
    .lin_evt(lin_evt), .lin_en(lin_en), .cs(cs),
    .rep_hit(rep_hit), .cs_rise(cs_rise)
  );

  assign rep_any    = |rep_hit;
  assign capture    = (ph == PH_RUN) && lp_enter;
  assign stop_wake  = (ph == PH_STOP) && (rep_any || cs_rise || xheld);
  assign sleep_wake = (ph == PH_SLEEP) && rep_any;
  assign stat_set   = (stop_wake || sleep_wake) ? rep_hit : '0;

  lpw_stat #(.NSW(NSW)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(stat_set),
    .rd_en(rd_en), .rd_addr(rd_addr), .sw_in(sw_in), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_RUN;
      run_md   <= MD_NORMAL;
      rcnt     <= '0;
      wake_irq <= 1'b0;
    end else begin
      wake_irq <= stop_wake && rep_any && !xheld;
      unique case (ph)
        PH_RUN: if (lp_enter) ph <= lp_sel ? PH_SLEEP : PH_STOP;
        PH_STOP: if (stop_wake) begin
          ph     <= PH_RUN;
          run_md <= xheld ? xrst_target(nreq_cfg) : MD_NORMAL;
        end
        PH_SLEEP: if (sleep_wake) begin
          ph     <= PH_RSTOUT;
          rcnt   <= '0;
          run_md <= MD_NORMAL;
        end
        PH_RSTOUT: begin
          if (rcnt == RCW'(RST_CYC - 1)) ph <= PH_RUN;
          else                           rcnt <= rcnt + 1'b1;
        end
        default: ph <= PH_RUN;
      endcase
    end
  end

  always_comb begin
    unique case (ph)
      PH_STOP:  mode = MD_STOP;
      PH_SLEEP: mode = MD_SLEEP;
      PH_RUN:   mode = run_md;
      default:  mode = MD_NORMAL;
    endcase
  end

  assign reg_en   = (ph != PH_SLEEP);
  assign host_rst = xheld || (ph == PH_RSTOUT);

  // R2
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
  // R10
  run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RUN) |=> !wake_irq);
  // R3
  sleep_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_wake |=> (host_rst && reg_en && mode == MD_NORMAL));
  // R3
  sleep_regoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SLEEP) |-> !reg_en);
  // R5
  xrst_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xheld |=> !wake_irq);
  // R4
  cs_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOP && cs_rise && !rep_any && !xheld) |=> (!wake_irq && mode == MD_NORMAL));
endmodule

// File: tb/tb_lp_wake_ctrl.sv
module tb_lp_wake_ctrl;
  localparam int NSW = 4;
  localparam int DGL = 75;
  localparam int RSTC = 16;
  localparam int STW = NSW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_enter = 0, lp_sel = 0, nreq_cfg = 0;
  logic [NSW-1:0] sw_in = '0, sw_en = '0;
  logic mux_on = 0;
  logic [1:0] mux_idx = '0;
  logic cyc_evt = 0, cyc_en = 0, frc_evt = 0, frc_en = 0, lin_evt = 0, lin_en = 0;
  logic cs = 0, ext_rst_n = 1, rd_en = 0, rd_addr = 0;
  logic [STW-1:0] rd_data;
  logic wake_irq, reg_en, host_rst;
  logic [1:0] mode;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lp_wake_ctrl #(.NSW(NSW), .DGL_CYC(DGL), .RST_CYC(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .lp_enter(lp_enter), .lp_sel(lp_sel), .nreq_cfg(nreq_cfg),
    .sw_in(sw_in), .sw_en(sw_en), .mux_on(mux_on), .mux_idx(mux_idx),
    .cyc_evt(cyc_evt), .cyc_en(cyc_en), .frc_evt(frc_evt), .frc_en(frc_en),
    .lin_evt(lin_evt), .lin_en(lin_en), .cs(cs), .ext_rst_n(ext_rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wake_irq(wake_irq), .reg_en(reg_en), .host_rst(host_rst), .mode(mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter(input logic sel);
    lp_enter = 1; lp_sel = sel;
    tick();
    lp_enter = 0;
  endtask

  task automatic read_reg(input logic a, output logic [STW-1:0] v);
    rd_en = 1; rd_addr = a;
    #1 v = rd_data;
    tick();
    rd_en = 0; rd_addr = 0;
  endtask

  // src: 0 switch, 1 cyclic, 2 forced, 3 LIN
  function automatic logic [STW-1:0] exp_bits(input int src, input int k);
    case (src)
      0: return (sw_en[k] && !(mux_on && mux_idx == 2'(k))) ? STW'(1 << k) : '0;
      1: return cyc_en ? STW'(1 << NSW) : '0;
      2: return (frc_en && !cyc_en) ? STW'(1 << (NSW + 1)) : '0;
      default: return lin_en ? STW'(1 << (NSW + 2)) : '0;
    endcase
  endfunction

  task automatic inject(input int src, input int k);
    case (src)
      0: sw_in[k] = ~sw_in[k];
      1: cyc_evt = 1;
      2: frc_evt = 1;
      default: lin_evt = 1;
    endcase
    tick();
    cyc_evt = 0; frc_evt = 0; lin_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [STW-1:0] v;
    int hr;
    void'($urandom(32'd77));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 mode", 32'(mode), 0);
    check("R1 reg_en", 32'(reg_en), 1);
    check("R1 host_rst", 32'(host_rst), 0);
    check("R1 irq", 32'(wake_irq), 0);
    read_reg(0, v); check("R1 status", 32'(v), 0);

    // R9 switch levels
    sw_in = 4'b1010;
    read_reg(1, v); check("R9 sw levels", 32'(v), 32'h0A);

    // R10 ignored in Normal
    cyc_en = 1; lin_en = 1;
    inject(1, 0);
    check("R10 no irq in normal", 32'(wake_irq), 0);
    read_reg(0, v); check("R10 no status in normal", 32'(v), 0);

    // R2 Stop wake by LIN
    enter(0);
    check("R2 stop mode", 32'(mode), 1);
    inject(3, 0);
    check("R2 irq", 32'(wake_irq), 1);
    check("R2 mode normal", 32'(mode), 0);
    tick();
    check("R2 irq one cycle", 32'(wake_irq), 0);
    inject(1, 0);  // after the wake: ignored
    read_reg(0, v); check("R8 LIN bit / R10 first only", 32'(v), 32'h40);
    read_reg(0, v); check("R8 clear on read", 32'(v), 0);

    // R4 CS in Stop
    enter(0);
    cs = 1; tick();
    check("R4 cs wake mode", 32'(mode), 0);
    check("R4 cs no irq", 32'(wake_irq), 0);
    cs = 0;
    read_reg(0, v); check("R4 cs no status", 32'(v), 0);

    // R4 CS in Sleep ignored, R3 sleep wake
    enter(1);
    check("R3 sleep mode", 32'(mode), 2);
    check("R3 reg off", 32'(reg_en), 0);
    cs = 1; tick(); cs = 0;
    check("R4 cs ignored in sleep", 32'(mode), 2);
    inject(3, 0);
    hr = 0;
    for (int i = 0; i < RSTC + 4; i++) begin
      if (host_rst) hr++;
      if (i == 0) begin
        check("R3 reg back on", 32'(reg_en), 1);
        check("R3 mode reads normal", 32'(mode), 0);
        check("R3 no irq", 32'(wake_irq), 0);
      end
      tick();
    end
    check("R3 reset length", 32'(hr), RSTC);
    check("R3 final mode", 32'(mode), 0);
    read_reg(0, v); check("R8 sleep LIN status", 32'(v), 32'h40);

    // R6 muxed switch blocked
    sw_en = 4'hF; mux_on = 1; mux_idx = 2;
    cyc_en = 0; lin_en = 0;
    enter(0);
    inject(0, 2);
    check("R6 muxed switch ignored", 32'(mode), 1);
    inject(0, 1);
    check("R6 switch wake irq", 32'(wake_irq), 1);
    read_reg(0, v); check("R6 switch status", 32'(v), 32'h02);
    mux_on = 0; sw_en = '0;

    // R7 exclusivity
    cyc_en = 1; frc_en = 1;
    enter(0);
    inject(2, 0);
    check("R7 forced blocked by cyclic", 32'(mode), 1);
    inject(1, 0);
    check("R7 cyclic wakes", 32'(mode), 0);
    read_reg(0, v); check("R7 cyclic status", 32'(v), 32'h10);
    cyc_en = 0;
    enter(0);
    inject(2, 0);
    read_reg(0, v); check("R7 forced status", 32'(v), 32'h20);
    frc_en = 0;

    // R8 sticky across wakes
    lin_en = 1; cyc_en = 1;
    enter(0); inject(3, 0);
    enter(0); inject(1, 0);
    read_reg(0, v); check("R8 sticky", 32'(v), 32'h50);
    lin_en = 0; cyc_en = 0;

    // R5 external reset from Stop
    nreq_cfg = 1;
    enter(0);
    ext_rst_n = 0;
    repeat (DGL - 1) tick();
    check("R5 before deglitch", 32'(host_rst), 0);
    tick();
    check("R5 host_rst after deglitch", 32'(host_rst), 1);
    tick();
    check("R5 mode normal request", 32'(mode), 3);
    check("R5 no irq", 32'(wake_irq), 0);
    ext_rst_n = 1; tick();
    check("R5 release no hold-off", 32'(host_rst), 0);
    read_reg(0, v); check("R5 no status", 32'(v), 0);
    nreq_cfg = 0;
    enter(0);
    ext_rst_n = 0; repeat (DGL + 1) tick(); ext_rst_n = 1;
    check("R5 mode normal cfg0", 32'(mode), 0);
    tick();
    // short glitch
    ext_rst_n = 0; hr = 0;
    for (int i = 0; i < DGL - 1; i++) begin tick(); if (host_rst) hr++; end
    ext_rst_n = 1; tick(); if (host_rst) hr++;
    check("R5 glitch filtered", 32'(hr), 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic sel;
      int src, k;
      logic [STW-1:0] eb;
      sel = 1'($urandom_range(0, 1));
      sw_en = 4'($urandom); mux_on = 1'($urandom); mux_idx = 2'($urandom);
      cyc_en = 1'($urandom); frc_en = 1'($urandom); lin_en = 1'($urandom);
      src = $urandom_range(0, 3); k = $urandom_range(0, NSW - 1);
      enter(sel);
      eb = exp_bits(src, k);
      inject(src, k);
      if (eb != '0) begin
        check("R2 R3 random wake mode", 32'(mode), 0);
        check("R2 random irq", 32'(wake_irq), 32'(!sel));
      end else begin
        check("R6 R7 random no wake", 32'(mode), sel ? 2 : 1);
        lin_en = 1;
        eb = exp_bits(3, 0);
        inject(3, 0);
      end
      repeat (RSTC + 1) tick();
      read_reg(0, v); check("R8 random status", 32'(v), 32'(eb));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule